// File: doc/BRIEF.md
# PRBS Error-Rate Meter

This block measures the quality of a received pseudo-random test pattern. A pattern comparator elsewhere in the receive path pulses an error strobe for each mismatched bit, and the framer pulses a multiframe strobe at every received CRC-4 multiframe boundary. The meter keeps two 8-bit counters: one for errors and one for multiframes. Software reads both counters and divides one by the other to get an error rate over a known stretch of time.

Both counters sit behind a byte-wide register port with a write strobe and combinational read data. A write to the error counter loads that counter and also zeroes the multiframe counter in the same cycle. This lets software open a fresh measurement window with a single access. When the error counter wraps, a sticky overflow flag is set. That flag drives an interrupt line through a mask bit.

Top module: `prbs_rate_meter`

## Requirements
- R1: After synchronous reset, the error counter (address 0), the multiframe counter (address 1), the overflow flag (status address 2, bit 0) and the interrupt enable (mask address 3, bit 0) are all zero, and `irq` is low.
- R2: Each clock cycle in which `err_strobe` is high and no write targets address 0, the error counter goes up by one.
- R3: Each clock cycle in which `mf_strobe` is high and no write targets address 0 or 1, the multiframe counter goes up by one.
- R4: A write to address 0 loads the written byte into the error counter, and on the same clock edge it sets the multiframe counter to zero.
- R5: A write to address 1 loads the written byte into the multiframe counter and leaves the error counter unchanged.
- R6: When a strobe arrives in the same cycle as a write that loads or clears the counter it would advance, the write takes effect and the strobe is discarded.
- R7: Both counters wrap from 255 to 0. Only a wrap of the error counter sets the overflow flag.
- R8: Writing a byte with bit 0 set to address 2 clears the overflow flag. Writing bit 0 as 0 leaves the flag unchanged. If an overflow occurs in the same cycle as a clear, the flag ends up set.
- R9: A write to address 3 stores bit 0 as the interrupt enable. `irq` is high exactly when both the overflow flag and the enable are set.
- R10: Reads have no side effects. Bits 7..1 of addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_strobe | input | 1 | One pattern bit error, one-cycle pulse |
| mf_strobe | input | 1 | Received multiframe boundary, one-cycle pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The assertions assume that the strobes and the register write are sampled once per clock edge. A strobe that is held high for several cycles therefore counts once per cycle. The assertions also assume that every address value decodes to a defined register, so no write is ever lost to an undecoded address. The stimulus changes inputs only just after a clock edge and uses addresses 0 to 3 only. It deliberately places strobes in the same cycle as writes, and places overflows in the same cycle as flag clears, so that the precedence rules are exercised rather than avoided.

// File: rtl/prbs_meas_pkg.sv
package prbs_meas_pkg;

    localparam int CNT_W  = 8;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_ERRCNT = 2'd0,
        RA_MFCNT  = 2'd1,
        RA_STATUS = 2'd2,
        RA_MASK   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             inc;
        logic             load;
        logic [CNT_W-1:0] value;
    } cnt_ctl_t;

    typedef struct packed {
        logic wr_err;
        logic wr_mf;
        logic wr_stat;
        logic wr_mask;
    } wr_dec_t;

    function automatic logic [REG_W-1:0] flag_to_byte(input logic b);
        return {{(REG_W-1){1'b0}}, b};
    endfunction

    function automatic wr_dec_t decode_write(input logic wr, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d.wr_err  = wr && (a == RA_ERRCNT);
        d.wr_mf   = wr && (a == RA_MFCNT);
        d.wr_stat = wr && (a == RA_STATUS);
        d.wr_mask = wr && (a == RA_MASK);
        return d;
    endfunction

endpackage

// File: rtl/rate_counter.sv
module rate_counter
    import prbs_meas_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (ctl.load)
            count_q <= ctl.value;
        else if (ctl.inc)
            count_q <= count_q + 1'b1;
    end

    assign wrap  = ctl.inc && !ctl.load && (count_q == TOP);
    assign count = count_q;

    // R2 / R3: a strobe without a competing write advances the count by one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (ctl.inc && !ctl.load) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    // R6: a load always takes precedence over a strobe
    a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (count_q == $past(ctl.value)));

    // R7: a wrap always lands on zero
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count_q == '0));

endmodule

// File: rtl/ovf_status.sv
module ovf_status (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic en_wr,
    input  logic en_val,
    output logic sticky,
    output logic enable,
    output logic irq
);
    logic sticky_q, enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
            enable_q <= 1'b0;
        end else begin
            if (set)
                sticky_q <= 1'b1;
            else if (clr)
                sticky_q <= 1'b0;
            if (en_wr)
                enable_q <= en_val;
        end
    end

    assign sticky = sticky_q;
    assign enable = enable_q;
    assign irq    = sticky_q && enable_q;

    // R8: the set side has priority over a concurrent clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> sticky_q);

    // R8: a clear with no overflow empties the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !sticky_q);

    // R8: the flag never drops without a clear request
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (sticky_q && !clr) |=> sticky_q);

endmodule

// File: rtl/prbs_rate_meter.sv
module prbs_rate_meter
    import prbs_meas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_strobe,
    input  logic              mf_strobe,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    wr_dec_t          dec;
    cnt_ctl_t         err_ctl, mf_ctl;
    logic [CNT_W-1:0] err_cnt, mf_cnt;
    logic             err_wrap, mf_wrap_unused;
    logic             sticky, enable;

    assign dec = decode_write(reg_wr, reg_addr);

    always_comb begin
        err_ctl.inc   = err_strobe;
        err_ctl.load  = dec.wr_err;
        err_ctl.value = CNT_W'(reg_wdata);

        mf_ctl.inc    = mf_strobe;
        mf_ctl.load   = dec.wr_err || dec.wr_mf;
        mf_ctl.value  = dec.wr_err ? '0 : CNT_W'(reg_wdata);
    end

    rate_counter i_err_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (err_ctl),
        .count (err_cnt),
        .wrap  (err_wrap)
    );

    rate_counter i_mf_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (mf_ctl),
        .count (mf_cnt),
        .wrap  (mf_wrap_unused)
    );

    ovf_status i_status (
        .clk    (clk),
        .rst    (rst),
        .set    (err_wrap),
        .clr    (dec.wr_stat && reg_wdata[0]),
        .en_wr  (dec.wr_mask),
        .en_val (reg_wdata[0]),
        .sticky (sticky),
        .enable (enable),
        .irq    (irq)
    );

    always_comb begin
        unique case (reg_addr)
            RA_ERRCNT: reg_rdata = REG_W'(err_cnt);
            RA_MFCNT:  reg_rdata = REG_W'(mf_cnt);
            RA_STATUS: reg_rdata = flag_to_byte(sticky);
            RA_MASK:   reg_rdata = flag_to_byte(enable);
            default:   reg_rdata = '0;
        endcase
    end

    // R4: a write to the error counter empties the multiframe counter
    a_r4_window_restart: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_ERRCNT) |=> (mf_cnt == '0));

    // R5: a multiframe load does not disturb the error counter
    a_r5_err_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_MFCNT && !err_strobe) |=> $stable(err_cnt));

    // R9: the interrupt needs both the flag and the enable
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (reg_rdata[0] || reg_addr != RA_STATUS) && sticky && enable);

    // R7: only an error-counter wrap raises the flag
    a_r7_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky) |-> $past(err_strobe));

endmodule

// File: tb/test_prbs_rate_meter.sv
`timescale 1ns/1ps
module test_prbs_rate_meter;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       err_strobe, mf_strobe, reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int bad    = 0;
    int m_err = 0, m_mf = 0, m_stk = 0, m_en = 0;

    always #HALF clk = ~clk;

    prbs_rate_meter i_prbs_rate_meter (
        .clk(clk), .rst(rst), .err_strobe(err_strobe), .mf_strobe(mf_strobe),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic step(input logic e, input logic m, input logic w,
                        input int a, input int d);
        int ne, nm, ns, nk;
        logic ld_err;
        ld_err = w && a == 0;
        ne = m_err; nm = m_mf; ns = m_stk; nk = m_en;
        if (ld_err) begin
            ne = d; nm = 0;
        end else begin
            if (e) ne = (m_err + 1) % 256;
            if (w && a == 1) nm = d;
            else if (m) nm = (m_mf + 1) % 256;
        end
        if (w && a == 2 && d % 2 == 1) ns = 0;
        if (!ld_err && e && m_err == 255) ns = 1;
        if (w && a == 3) nk = d % 2;
        err_strobe = e; mf_strobe = m; reg_wr = w;
        reg_addr = 2'(a); reg_wdata = 8'(d);
        @(posedge clk);
        #1;
        err_strobe = 0; mf_strobe = 0; reg_wr = 0;
        m_err = ne; m_mf = nm; m_stk = ns; m_en = nk;
    endtask

    task automatic check_all(input string tag);
        int v;
        rd(2'd0, v); chk({tag, " err"}, v, m_err);
        rd(2'd1, v); chk({tag, " mf"}, v, m_mf);
        rd(2'd2, v); chk({tag, " status"}, v, m_stk);
        rd(2'd3, v); chk({tag, " mask"}, v, m_en);
        chk({tag, " irq"}, int'(irq), m_stk & m_en);
    endtask

    initial begin
        #(2 * HALF * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int v;
        rst = 1; err_strobe = 0; mf_strobe = 0; reg_wr = 0;
        reg_addr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check_all("R1 reset");

        // R2 R3 R7 R9: long sweep through the error wrap, mask off
        for (int i = 0; i < 300; i++) begin
            step(1'b1, (i % 3) == 0, 1'b0, 0, 0);
            check_all("R2 R3 R7 sweep");
        end

        // R8: writing 0 keeps the flag, writing 1 clears it
        step(1'b0, 1'b0, 1'b1, 2, 254);
        check_all("R8 write zero");
        step(1'b0, 1'b0, 1'b1, 2, 1);
        check_all("R8 clear");

        // R9: enable, then overflow raises irq
        step(1'b0, 1'b0, 1'b1, 3, 255);
        check_all("R9 enable");
        step(1'b0, 1'b0, 1'b1, 0, 250);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0, 1'b0, 0, 0);
            check_all("R9 irq");
        end

        // R4 R5 R6: loads sweep with colliding strobes
        for (int x = 0; x < 256; x += 17) begin
            step(1'b1, 1'b1, 1'b1, 0, x);
            check_all("R4 R6 err load");
            step(1'b0, 1'b1, 1'b1, 1, 255 - x);
            check_all("R5 R6 mf load");
            step(1'b1, 1'b1, 1'b0, 0, 0);
            check_all("R2 R3 after load");
        end

        // R7: multiframe wrap leaves the flag alone
        step(1'b0, 1'b0, 1'b1, 2, 1);
        step(1'b0, 1'b0, 1'b1, 1, 255);
        step(1'b0, 1'b1, 1'b0, 0, 0);
        check_all("R7 mf wrap");

        // R8: overflow and clear in one cycle leaves the flag set
        step(1'b0, 1'b0, 1'b1, 0, 255);
        step(1'b1, 1'b0, 1'b1, 2, 1);
        check_all("R8 set wins");

        // R9: disable the interrupt while the flag stays set
        step(1'b0, 1'b0, 1'b1, 3, 0);
        check_all("R9 disable");

        // R10: repeated reads change nothing, upper bits zero
        for (int i = 0; i < 4; i++) begin
            for (int a = 0; a < 4; a++) rd(2'(a), v);
            @(posedge clk); #1;
        end
        check_all("R10 reads");
        rd(2'd2, v); chk("R10 status upper", v / 2, 0);
        rd(2'd3, v); chk("R10 mask upper", v / 2, 0);

        // R1: reset mid-run clears everything
        step(1'b1, 1'b1, 1'b1, 3, 1);
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        m_err = 0; m_mf = 0; m_stk = 0; m_en = 0;
        check_all("R1 re-reset");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule